// File: doc/BRIEF.md
# Queued-Duty Pulse-Width Modulator

This block drives one pulse-width modulated output. The duty value comes from a short queue that software fills through a small register port. The output changes duty only at a period boundary, so a new sample never disturbs a pulse that is already under way. A programmable divider turns the chosen tick source into count steps. It can step on every clock or only on an external tick strobe. A 16-bit period register sets how many count steps make up one period.

When a period ends, the generator takes the next queued sample. If the queue is empty, it keeps the sample it already has. The period register holds the length minus two. Writing it starts a new period at once. A self-clearing reset bit empties the queue. Separate run enables decide whether the generator keeps counting while the chip reports a doze, wait or debug condition.

Top module: `pwm_queue`

## Requirements
- R1: After reset, `pwm_out` is low, the queue is empty and the status register reads 0x100.
- R2: One period lasts (P+2)×(D+1) clock cycles, where P is the period register and D is control bits [15:8], which hold the divide ratio minus one.
- R3: Within a period, the output is high while the count (0 to P+1) is below the active sample. A sample of 0 keeps the output low. A sample of P+2 or more keeps it high.
- R4: Samples leave the 4-entry queue in write order. One sample is taken when the enable bit rises and one at each period rollover. With the queue empty, the active sample is reused.
- R5: A sample written during a period does not change that period's output.
- R6: A write to the period register (address 2) restarts the count at zero on the next cycle.
- R7: Status register (address 3): fill level in bits [7:0], empty in bit 8, full in bit 9, overflow in bit 10. A sample write while the queue is full is dropped and sets overflow. Overflow stays set until a soft reset.
- R8: Writing control bit 5 empties the queue, clears overflow, zeroes the active sample and restarts the count. Bit 5 reads back as 1 for one cycle, then as 0.
- R9: Control bit 0 enables the generator. While it is 0, `pwm_out` is low, and writing 0 to the control register stops the output.
- R10: Control bit 1 chooses the tick source: 0 steps on every clock, 1 steps only on cycles where `ext_tick` is high.
- R11: Control bits 2, 3 and 4 are the run enables for `doze_req`, `wait_req` and `dbg_req`. While a request is high and its run enable is 0, the count and the output stay frozen.
- R12: Register map: control at address 0, sample at 1, period at 2, status at 3. A read of address 1 returns the active sample, and control reads return the stored fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | 32 | Read data, combinational |
| ext_tick | input | 1 | Alternative count tick |
| doze_req | input | 1 | Doze condition from the chip |
| wait_req | input | 1 | Wait condition from the chip |
| dbg_req | input | 1 | Debug halt condition from the chip |
| pwm_out | output | 1 | Modulated output |

## Verification
The main check sweeps every sample from 0 to P+3 against periods 0 to 4, at divide ratios 1 and 2. It counts high cycles over exactly one period. Together these cases separate the constant-low case, the constant-high case and the proportional range, and they expose any error in the plus-two rule. Multi-period runs compare each period against the queue order, including a mid-period push and the reuse of the last sample. A dropped overflow value is chosen so it would show up if it were wrongly accepted. Further runs freeze the count through the external tick source and the debug request, and restart it with a period write, to show that each path holds or clears the count.

// File: rtl/pwm_queue.sv
module pwm_queue #(
  parameter int CW    = 16,
  parameter int PSW   = 8,
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_waddr,
  input  logic [31:0] reg_wdata,
  input  logic [1:0]  reg_raddr,
  output logic [31:0] reg_rdata,
  input  logic        ext_tick,
  input  logic        doze_req,
  input  logic        wait_req,
  input  logic        dbg_req,
  output logic        pwm_out
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic           en_q, src_q, doze_run_q, wait_run_q, dbg_run_q, srst_q;
  logic [PSW-1:0] div_q, pre_q;
  logic [CW-1:0]  period_q, active_q;
  logic [CW:0]    cnt_q, last_cnt;
  logic [CW-1:0]  mem [DEPTH];
  logic [AW-1:0]  rd_ptr, wr_ptr;
  logic [LW-1:0]  level;
  logic           ovf_q;

  wire wr_ctrl = reg_we && reg_waddr == 2'd0;
  wire wr_samp = reg_we && reg_waddr == 2'd1;
  wire wr_per  = reg_we && reg_waddr == 2'd2;
  wire do_srst = wr_ctrl && reg_wdata[5];
  wire en_rise = wr_ctrl && reg_wdata[0] && !en_q;

  wire full  = level == LW'(DEPTH);
  wire empty = level == '0;

  wire paused = (doze_req && !doze_run_q) || (wait_req && !wait_run_q) ||
                (dbg_req && !dbg_run_q);
  wire tick   = en_q && !paused && (src_q ? ext_tick : 1'b1);
  wire step   = tick && pre_q == div_q;
  assign last_cnt = {1'b0, period_q} + {{CW{1'b0}}, 1'b1};
  wire wrap   = step && cnt_q == last_cnt;

  wire pop  = !do_srst && !empty &&
              (en_rise || (wrap && !wr_ctrl && !wr_per));
  wire push = wr_samp && !full;

  assign pwm_out = en_q && ({1'b0, active_q} > cnt_q);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; src_q <= 1'b0; doze_run_q <= 1'b0;
      wait_run_q <= 1'b0; dbg_run_q <= 1'b0; srst_q <= 1'b0;
      div_q <= '0; period_q <= '0;
    end else begin
      srst_q <= do_srst;
      if (wr_ctrl) begin
        en_q       <= reg_wdata[0];
        src_q      <= reg_wdata[1];
        doze_run_q <= reg_wdata[2];
        wait_run_q <= reg_wdata[3];
        dbg_run_q  <= reg_wdata[4];
        div_q      <= reg_wdata[8 +: PSW];
      end
      if (wr_per) period_q <= reg_wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (wr_ctrl || wr_per) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (tick) begin
      if (step) begin
        pre_q <= '0;
        cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0; wr_ptr <= '0; level <= '0;
      ovf_q <= 1'b0; active_q <= '0;
    end else if (do_srst) begin
      rd_ptr <= '0; wr_ptr <= '0; level <= '0;
      ovf_q <= 1'b0; active_q <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop) begin
        rd_ptr   <= nxt(rd_ptr);
        active_q <= mem[rd_ptr];
      end
      if (wr_samp && full) ovf_q <= 1'b1;
      level <= level + LW'(push) - LW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= reg_wdata[CW-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_raddr)
      2'd0: begin
        reg_rdata[0] = en_q;
        reg_rdata[1] = src_q;
        reg_rdata[2] = doze_run_q;
        reg_rdata[3] = wait_run_q;
        reg_rdata[4] = dbg_run_q;
        reg_rdata[5] = srst_q;
        reg_rdata[8 +: PSW] = div_q;
      end
      2'd1: reg_rdata[CW-1:0] = active_q;
      2'd2: reg_rdata[CW-1:0] = period_q;
      default: begin
        reg_rdata[LW-1:0] = level;
        reg_rdata[8]  = empty;
        reg_rdata[9]  = full;
        reg_rdata[10] = ovf_q;
      end
    endcase
  end
endmodule

module pwm_queue_chk #(
  parameter int CW    = 16,
  parameter int DEPTH = 4,
  parameter int LW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          pwm_out,
  input logic          paused,
  input logic          any_wr,
  input logic          srst_wr,
  input logic [CW:0]   cnt,
  input logic [CW:0]   last_cnt,
  input logic [CW-1:0] active,
  input logic [LW-1:0] level,
  input logic          full,
  input logic          empty,
  input logic          ovf
);
  // R7
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  // R7
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !srst_wr |=> ovf);
  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out);
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_cnt);
  // R5
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active) |-> cnt == '0);
  // R11
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && paused && !any_wr |=> $stable(cnt));
endmodule

bind pwm_queue pwm_queue_chk #(.CW(CW), .DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .pwm_out(pwm_out), .paused(paused),
  .any_wr(reg_we), .srst_wr(do_srst), .cnt(cnt_q), .last_cnt(last_cnt),
  .active(active_q), .level(level), .full(full), .empty(empty), .ovf(ovf_q)
);

// File: tb/pwm_queue_tb.sv
module pwm_queue_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_waddr = '0, reg_raddr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        ext_tick = 1'b0, doze_req = 1'b0, wait_req = 1'b0, dbg_req = 1'b0;
  logic        pwm_out;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  pwm_queue u_dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_raddr = a;
    #1 v = int'(reg_rdata);
  endtask

  task automatic measure(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out) highs++;
      @(negedge clk);
    end
  endtask

  function automatic int mn(input int a, input int b);
    return a < b ? a : b;
  endfunction

  initial begin
    int v, h, h2;
    int seq [5];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd3, v); chk("R1 status", v, 'h100);
    chk("R1 output", int'(pwm_out), 0);

    // R2/R3 sweep over period, sample and divider
    for (int d = 0; d < 2; d++)
      for (int p = 0; p < 5; p++)
        for (int s = 0; s <= p + 3; s++) begin
          wr(2'd0, 32'h20);
          wr(2'd2, p);
          wr(2'd1, s);
          wr(2'd0, 1 | (d << 8));
          measure((p + 2) * (d + 1), h);
          chk("R2/R3 highs per period", h, mn(s, p + 2) * (d + 1));
        end

    // R4/R5 queue order, mid-period push, reuse on empty (P=2, 4 counts)
    wr(2'd0, 32'h20);
    wr(2'd2, 2);
    wr(2'd1, 1); wr(2'd1, 3); wr(2'd1, 2);
    wr(2'd0, 1);
    measure(2, h);
    if (pwm_out) h++;
    wr(2'd1, 4);
    measure(1, h2);
    chk("R5 first period unaffected by push", h + h2, 1);
    seq = '{3, 2, 4, 4, 4};
    for (int k = 0; k < 5; k++) begin
      measure(4, h);
      chk("R4 period sample order", h, seq[k]);
    end
    rd(2'd1, v); chk("R12 active sample readback", v, 4);

    // R7 overflow and dropped write (P=14, 16 counts)
    wr(2'd0, 32'h20);
    wr(2'd2, 14);
    for (int k = 0; k < 4; k++) wr(2'd1, 10 + k);
    rd(2'd3, v); chk("R7 full status", v, 'h204);
    wr(2'd1, 14);
    rd(2'd3, v); chk("R7 overflow status", v, 'h604);
    wr(2'd0, 1);
    rd(2'd3, v); chk("R7 overflow sticky after pop", v, 'h403);
    for (int k = 0; k < 5; k++) begin
      measure(16, h);
      chk("R7 dropped value never used", h, (k < 4) ? 10 + k : 13);
    end

    // R8 soft reset
    wr(2'd0, 32'h0);
    wr(2'd1, 7); wr(2'd1, 8);
    wr(2'd0, 32'h20);
    rd(2'd0, v); chk("R8 reset bit set one cycle", (v >> 5) & 1, 1);
    rd(2'd3, v); chk("R8 queue flushed", v, 'h100);
    @(negedge clk);
    rd(2'd0, v); chk("R8 reset bit self-clears", (v >> 5) & 1, 0);
    rd(2'd1, v); chk("R8 active sample cleared", v, 0);
    rd(2'd2, v); chk("R12 period readback", v, 14);

    // R6 period write restarts (P=9, s=3)
    wr(2'd2, 9); wr(2'd1, 3); wr(2'd0, 1);
    repeat (5) @(negedge clk);
    chk("R6 low before restart", int'(pwm_out), 0);
    wr(2'd2, 9);
    chk("R6 high after restart", int'(pwm_out), 1);
    measure(11, h);
    chk("R6 full period after restart", h, 3);

    // R9 stop
    wr(2'd0, 0);
    measure(20, h);
    chk("R9 stopped output low", h, 0);

    // R10 external tick source (P=2, s=1)
    wr(2'd0, 32'h20); wr(2'd2, 2); wr(2'd1, 1);
    wr(2'd0, 32'h3);
    measure(20, h);
    chk("R10 frozen without ticks", h, 20);
    ext_tick = 1'b1;
    @(negedge clk);
    measure(4, h);
    chk("R10 counts on ticks", h, 1);
    ext_tick = 1'b0;

    // R11 debug freeze, doze run allowed (P=5, s=3)
    wr(2'd0, 32'h20); wr(2'd2, 5); wr(2'd1, 3); wr(2'd1, 3);
    wr(2'd0, 32'h5);
    @(negedge clk);
    dbg_req = 1'b1;
    measure(20, h);
    chk("R11 debug freezes output", h, 20);
    dbg_req = 1'b0;
    measure(6, h);
    chk("R11 resumes after debug", h, 2);
    doze_req = 1'b1;
    measure(7, h);
    chk("R11 doze with run enable keeps counting", h, 3);
    doze_req = 1'b0;
    rd(2'd0, v); chk("R12 control readback", v, 5);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule